// File: doc/BRIEF.md
# Warp Lane Exchange Crossbar

This block moves one 32-bit word per lane among the 32 lanes of a warp in a single registered step. Every destination lane picks a source lane and receives that lane's word, so a cross-lane exchange needs no trip through a scratch memory. The source lane comes from one of four addressing modes. It can be a free per-lane index. It can be the lane a shared distance below the destination, or the lane the same distance above it. It can also be the lane found by XOR-ing the destination number with a shared mask.

A caller presents the whole data vector, a mask of participating lanes, the mode code and either the per-lane indices or the shared distance/mask. It raises the strobe for one cycle. On the next cycle the permuted vector appears, together with one flag per lane. A lane whose source falls off the edge of the warp, whose source is not participating, or which is not participating itself keeps its own word and shows a cleared flag.

Top module: `lane_xchg`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_data` and `out_lane_ok` are all zero until the first strobe.
- R2: A strobe on `in_valid` at one rising edge makes the result and `out_valid`=1 visible after that edge. A cycle with no strobe drives `out_valid` to 0 and leaves `out_data` and `out_lane_ok` unchanged.
- R3: Mode code 0 (index): destination lane d receives the word of lane `in_idx` field d.
- R4: Mode code 1 (up): destination lane d reads lane d−k, where k is the shared parameter. When d−k < 0, lane d keeps its own word and its flag is 0.
- R5: Mode code 2 (down): destination lane d reads lane d+k. When d+k > 31, lane d keeps its own word and its flag is 0.
- R6: Mode code 3 (xor): destination lane d reads lane d XOR m, where m is the shared parameter.
- R7: When the selected source lane has its `in_active` bit clear, the destination keeps its own word and its flag is 0.
- R8: A destination lane whose own `in_active` bit is clear keeps its own word and its flag is 0.
- R9: Only the low 5 bits of each 8-bit `in_idx` field and of `in_param` are used. The upper 3 bits have no effect on any output.
- R10: Lane i uses bits [32i+31:32i] of `in_data` and `out_data`, bits [8i+7:8i] of `in_idx`, and bit i of `in_active` and `out_lane_ok`. Every lane that is not excluded by R4, R5, R7 or R8 carries flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | One-cycle request strobe |
| in_data | input | 1024 | Per-lane source words, lane i at [32i+31:32i] |
| in_active | input | 32 | Participating-lane mask |
| in_mode | input | 2 | 0 index, 1 up, 2 down, 3 xor |
| in_idx | input | 256 | Per-lane source index fields, 8 bits per lane |
| in_param | input | 8 | Shared shift distance or XOR mask |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 1024 | Permuted words |
| out_lane_ok | output | 32 | Per-lane flag: word came from a legal, active source |

## Verification
The hardest situation to reach is a lane excluded for more than one reason at once, or for a reason that is masked by another. Examples are an index pointing at an inactive lane while the destination itself is inactive, or a shift whose edge lanes coincide with inactive lanes. The stimulus combines sparse activity masks with index, shift and XOR requests. It also sets the upper bits of every index and parameter field, so any use of those bits moves a lane to a different source. Requests are sent both back to back and with idle gaps, so the hold behaviour is checked after each kind of result.

// File: rtl/lane_xchg_pkg.sv
package lane_xchg_pkg;

    typedef enum logic [1:0] {
        XM_INDEX = 2'd0,
        XM_UP    = 2'd1,
        XM_DOWN  = 2'd2,
        XM_XOR   = 2'd3
    } xmode_e;

endpackage

// File: rtl/lane_src_sel.sv
module lane_src_sel
    import lane_xchg_pkg::*;
#(
    parameter int LANES = 32,
    parameter int IDXW  = 8,
    localparam int IW   = $clog2(LANES)
) (
    input  xmode_e                   mode,
    input  logic [LANES*IDXW-1:0]    idx,
    input  logic [IDXW-1:0]          param,
    output logic [LANES*IW-1:0]      src,
    output logic [LANES-1:0]         in_range
);

    logic [IW-1:0] par_lo;
    assign par_lo = param[IW-1:0];

    logic unused_param_hi;
    assign unused_param_hi = ^param[IDXW-1:IW];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [IW:0] ME = (IW+1)'(i);
        logic [IW-1:0] own_idx;
        logic [IW:0]   up_w;
        logic [IW:0]   dn_w;
        logic          unused_idx_hi;

        assign own_idx       = idx[i*IDXW +: IW];
        assign unused_idx_hi = ^idx[i*IDXW+IW +: IDXW-IW];
        assign up_w          = ME - {1'b0, par_lo};
        assign dn_w          = ME + {1'b0, par_lo};

        always_comb begin
            src[i*IW +: IW] = ME[IW-1:0];
            in_range[i]     = 1'b1;
            unique case (mode)
                XM_INDEX: src[i*IW +: IW] = own_idx;
                XM_UP: begin
                    src[i*IW +: IW] = up_w[IW-1:0];
                    in_range[i]     = ~up_w[IW];
                end
                XM_DOWN: begin
                    src[i*IW +: IW] = dn_w[IW-1:0];
                    in_range[i]     = ~dn_w[IW];
                end
                XM_XOR: src[i*IW +: IW] = ME[IW-1:0] ^ par_lo;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lane_xbar.sv
module lane_xbar #(
    parameter int LANES = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] data,
    input  logic [LANES-1:0]    active,
    input  logic [LANES*IW-1:0] src,
    input  logic [LANES-1:0]    in_range,
    output logic [LANES*DW-1:0] res,
    output logic [LANES-1:0]    ok
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [IW-1:0] s;
        logic [DW-1:0] picked;
        logic          take;

        assign s      = src[i*IW +: IW];
        assign picked = data[s*DW +: DW];
        assign take   = in_range[i] & active[i] & active[s];
        assign ok[i]  = take;
        assign res[i*DW +: DW] = take ? picked : data[i*DW +: DW];
    end

endmodule

// File: rtl/lane_xchg.sv
module lane_xchg
    import lane_xchg_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32,
    parameter int IDXW  = 8,
    localparam int IW   = $clog2(LANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   in_data,
    input  logic [LANES-1:0]      in_active,
    input  logic [1:0]            in_mode,
    input  logic [LANES*IDXW-1:0] in_idx,
    input  logic [IDXW-1:0]       in_param,
    output logic                  out_valid,
    output logic [LANES*DW-1:0]   out_data,
    output logic [LANES-1:0]      out_lane_ok
);

    typedef struct packed {
        logic                vld;
        logic [LANES*DW-1:0] data;
        logic [LANES-1:0]    ok;
    } xchg_st_t;

    xchg_st_t st_d, st_q;

    logic [LANES*IW-1:0] src_w;
    logic [LANES-1:0]    range_w;
    logic [LANES*DW-1:0] res_w;
    logic [LANES-1:0]    ok_w;

    lane_src_sel #(.LANES(LANES), .IDXW(IDXW)) u_sel (
        .mode     (xmode_e'(in_mode)),
        .idx      (in_idx),
        .param    (in_param),
        .src      (src_w),
        .in_range (range_w)
    );

    lane_xbar #(.LANES(LANES), .DW(DW)) u_xbar (
        .data     (in_data),
        .active   (in_active),
        .src      (src_w),
        .in_range (range_w),
        .res      (res_w),
        .ok       (ok_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = res_w;
            st_d.ok   = ok_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_data    = st_q.data;
    assign out_lane_ok = st_q.ok;

endmodule

// File: rtl/lane_xchg_chk.sv
module lane_xchg_chk
    import lane_xchg_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32,
    parameter int IDXW  = 8,
    localparam int IW   = $clog2(LANES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [LANES*DW-1:0]   in_data,
    input logic [LANES-1:0]      in_active,
    input logic [1:0]            in_mode,
    input logic [IDXW-1:0]       in_param,
    input logic                  out_valid,
    input logic [LANES*DW-1:0]   out_data,
    input logic [LANES-1:0]      out_lane_ok
);

    p_strobe_to_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_drops_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_idle_holds_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_lane_ok)));

    p_zero_shift_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == XM_UP && in_param[IW-1:0] == '0 && (&in_active))
        |=> (out_data == $past(in_data) && (&out_lane_ok)));

    p_xor_full_warp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == XM_XOR && (&in_active)) |=> (&out_lane_ok));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        p_idle_lane_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_active[i])
            |=> (!out_lane_ok[i] && out_data[i*DW +: DW] == $past(in_data[i*DW +: DW])));

        p_cleared_flag_own_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_lane_ok[i] ||
                          out_data[i*DW +: DW] == $past(in_data[i*DW +: DW])));
    end

endmodule

bind lane_xchg lane_xchg_chk #(.LANES(LANES), .DW(DW), .IDXW(IDXW)) u_chk (.*);

// File: tb/lane_xchg_test.sv
module lane_xchg_test;

    localparam int LANES = 32;
    localparam int DW    = 32;
    localparam int IDXW  = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [LANES*DW-1:0]   in_data = '0;
    logic [LANES-1:0]      in_active = '0;
    logic [1:0]            in_mode = 2'd0;
    logic [LANES*IDXW-1:0] in_idx = '0;
    logic [IDXW-1:0]       in_param = '0;
    logic                  out_valid;
    logic [LANES*DW-1:0]   out_data;
    logic [LANES-1:0]      out_lane_ok;

    int checks = 0;
    int fails  = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    logic [LANES*DW-1:0] exp_d_q[$];
    logic [LANES-1:0]    exp_f_q[$];
    string               exp_t_q[$];
    logic [LANES*DW-1:0] last_d = '0;
    logic [LANES-1:0]    last_f = '0;

    always #2.5 clk = ~clk;

    lane_xchg uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_active(in_active), .in_mode(in_mode), .in_idx(in_idx),
        .in_param(in_param), .out_valid(out_valid), .out_data(out_data),
        .out_lane_ok(out_lane_ok)
    );

    function automatic logic [LANES*DW-1:0] make_data(input int seed);
        logic [LANES*DW-1:0] v;
        for (int i = 0; i < LANES; i++)
            v[i*DW +: DW] = {16'(seed * 97 + 3), 8'(i), 8'(i * 13 + seed)};
        return v;
    endfunction

    task automatic predict(input logic [LANES*DW-1:0] d, input logic [LANES-1:0] act,
                           input logic [1:0] mode, input logic [LANES*IDXW-1:0] idx,
                           input logic [IDXW-1:0] prm,
                           output logic [LANES*DW-1:0] ed, output logic [LANES-1:0] ef);
        int k;
        k = int'(prm % 32);
        for (int dl = 0; dl < LANES; dl++) begin
            int s;
            bit legal;
            legal = 1'b1;
            case (mode)
                2'd0: s = int'(idx[dl*IDXW +: IDXW] % 32);
                2'd1: begin s = dl - k; legal = (s >= 0); end
                2'd2: begin s = dl + k; legal = (s <= 31); end
                default: s = dl ^ k;
            endcase
            if (legal && act[dl] && act[s]) begin
                ed[dl*DW +: DW] = d[s*DW +: DW];
                ef[dl] = 1'b1;
            end else begin
                ed[dl*DW +: DW] = d[dl*DW +: DW];
                ef[dl] = 1'b0;
            end
        end
    endtask

    task automatic send(input string tag, input logic [LANES*DW-1:0] d,
                        input logic [LANES-1:0] act, input logic [1:0] mode,
                        input logic [LANES*IDXW-1:0] idx, input logic [IDXW-1:0] prm,
                        input int gap);
        logic [LANES*DW-1:0] ed;
        logic [LANES-1:0]    ef;
        @(negedge clk);
        predict(d, act, mode, idx, prm, ed, ef);
        exp_d_q.push_back(ed);
        exp_f_q.push_back(ef);
        exp_t_q.push_back(tag);
        in_valid  = 1'b1;
        in_data   = d;
        in_active = act;
        in_mode   = mode;
        in_idx    = idx;
        in_param  = prm;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = ~in_data;
            in_idx   = ~in_idx;
        end
    endtask

    // monitor: compares at the falling edge after each capture
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) begin
                checks++;
                if (out_valid) begin
                    if (exp_d_q.size() == 0) begin
                        fails++;
                        $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
                    end else begin
                        logic [LANES*DW-1:0] ed;
                        logic [LANES-1:0]    ef;
                        string               tg;
                        ed = exp_d_q.pop_front();
                        ef = exp_f_q.pop_front();
                        tg = exp_t_q.pop_front();
                        if (out_data !== ed || out_lane_ok !== ef) begin
                            fails++;
                            $display("FAIL %s flags actual %h expected %h data actual %h expected %h",
                                     tg, out_lane_ok, ef, out_data, ed);
                        end
                        last_d = ed;
                        last_f = ef;
                    end
                end else if (out_data !== last_d || out_lane_ok !== last_f) begin
                    fails++;
                    $display("FAIL R2 hold: flags actual %h expected %h data actual %h expected %h",
                             out_lane_ok, last_f, out_data, last_d);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [LANES*IDXW-1:0] ix;
        logic [LANES-1:0] sparse;
        sparse = 32'h0F0F_F0F0;

        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0 || out_lane_ok !== '0) begin
            fails++;
            $display("FAIL R1 during reset: valid %b data %h flags %h expected all zero",
                     out_valid, out_data, out_lane_ok);
        end
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R10: reverse permutation, full warp
        for (int i = 0; i < LANES; i++) ix[i*IDXW +: IDXW] = 8'(31 - i);
        send("R3", make_data(1), '1, 2'd0, ix, 8'h00, 2);

        // R3: broadcast from lane 7, back to back with next
        for (int i = 0; i < LANES; i++) ix[i*IDXW +: IDXW] = 8'd7;
        send("R3", make_data(2), '1, 2'd0, ix, 8'h00, 0);

        // R9: upper index bits set
        for (int i = 0; i < LANES; i++) ix[i*IDXW +: IDXW] = {3'b101, 5'(i + 5)};
        send("R9", make_data(3), '1, 2'd0, ix, 8'h00, 1);

        // R4: up by 3, edge lanes keep own
        send("R4", make_data(4), '1, 2'd1, ix, 8'd3, 1);
        // R4: up by 0
        send("R4", make_data(5), '1, 2'd1, ix, 8'd0, 0);
        // R4 R9: up with upper param bits set, distance 2
        send("R9", make_data(6), '1, 2'd1, ix, 8'hE2, 2);

        // R5: down by 5, then by 31
        send("R5", make_data(7), '1, 2'd2, ix, 8'd5, 1);
        send("R5", make_data(8), '1, 2'd2, ix, 8'd31, 1);
        send("R9", make_data(9), '1, 2'd2, ix, 8'h61, 1);

        // R6: butterflies
        send("R6", make_data(10), '1, 2'd3, ix, 8'd1, 0);
        send("R6", make_data(11), '1, 2'd3, ix, 8'd16, 0);
        send("R6", make_data(12), '1, 2'd3, ix, 8'd31, 1);
        send("R9", make_data(13), '1, 2'd3, ix, 8'hA4, 1);

        // R7 R8: sparse activity with index, shift and xor
        for (int i = 0; i < LANES; i++) ix[i*IDXW +: IDXW] = 8'((i * 5 + 3) % 32);
        send("R7", make_data(14), sparse, 2'd0, ix, 8'd0, 1);
        send("R8", make_data(15), sparse, 2'd1, ix, 8'd4, 1);
        send("R7", make_data(16), sparse, 2'd2, ix, 8'd2, 0);
        send("R8", make_data(17), sparse, 2'd3, ix, 8'd8, 1);
        send("R8", make_data(18), '0, 2'd3, ix, 8'd1, 2);
        send("R7", make_data(19), 32'h0000_0001, 2'd0, '0, 8'd0, 3);

        repeat (3) @(negedge clk);
        checks++;
        if (exp_d_q.size() != 0) begin
            fails++;
            $display("FAIL R2 results missing: actual %0d pending expected 0", exp_d_q.size());
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule